// File: doc/BRIEF.md
# Eight-Channel Counter Event Interrupt Hub

This block holds the shared control and status logic for a bank of eight counter channels that sit on an 8-bit register bus. Each channel reports four event pulses from its counter: carry, borrow, compare and index. A 2-bit flag function per channel picks which of those events may raise an interrupt for that channel. A rising edge of the picked event latches a pending bit, but only while the channel's enable bit is set. The pending bits are combined into a single active-high interrupt line, which is gated by a global interrupt-function enable.

The same register space holds a channel operation register and two read-only views. The operation register drives a global counter reset line and the interrupt-function enable, and any write to it clears every pending bit. One view returns the live index input levels. The other is a cable status register: each bit has an active-low fault-detect enable, and a 0 read on an enabled bit reports a cable fault. The counters themselves sit outside this block. Software uses the per-channel control addresses only to set the flag function. The block ignores every other control write and every write to a data address.

Top module: `ctr_irq_hub`

## Requirements
- R1: After reset the status (0x10), operation (0x11) and enable (0x12) registers read 0x00, the cable status register (0x17) reads 0xFF with every cable input low, and both `irq` and `cnt_reset` are low.
- R2: A write to control address 2n+1 (n = 0..7) with wdata[6:5] = 2'b10 loads channel n's flag function from wdata[4:3]. Control writes with any other wdata[6:5] value, and writes to data addresses 2n, leave the function unchanged.
- R3: Flag function codes pick the interrupt event: 0 = carry, 1 = compare, 2 = carry or borrow, 3 = index. The events that are not picked never set the pending bit.
- R4: Status bit n (address 0x10, channel 0 in bit 0) sets on a rising edge of channel n's picked event, but only if bit n of the enable register (0x12) is 1. It then stays set until it is cleared.
- R5: An event held high sets its pending bit once. After a clear, it cannot set the bit again until it has gone low and risen again.
- R6: Any write to address 0x11 clears all pending bits, whatever the data.
- R7: Bit 0 of register 0x11 drives `cnt_reset` (1 = hold the counters in reset, 0 = let them run). Bit 2 is the interrupt-function enable. Both read back at 0x11.
- R8: `irq` is high exactly when at least one pending bit is set and the interrupt-function enable is 1.
- R9: Address 0x16 returns the live `idx_level` inputs, channel n in bit n.
- R10: Writing 0 to bit n of address 0x17 enables cable fault detection for channel n. Reading bit n returns 1 while the bit is masked, and returns the `cable_ok` input (0 = fault) while it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| ev_carry | input | 8 | Carry event per channel |
| ev_borrow | input | 8 | Borrow event per channel |
| ev_compare | input | 8 | Compare event per channel |
| ev_index | input | 8 | Index event per channel |
| idx_level | input | 8 | Live index input level per channel |
| cable_ok | input | 8 | Cable status per channel, 0 = fault |
| irq | output | 1 | Interrupt request, active high |
| cnt_reset | output | 1 | Global counter reset |

## Verification
The main sweep sets all eight channels to one flag function, then pulses each of the four event kinds on each channel in turn. The full 4x4x8 grid shows whether the right event is picked, whether only the pulsed channel's bit sets, and whether a borrow counts only under function 2. Separate patterns cover other cases:
- An enable mask with one bit cleared, which separates gating by the enable from the edge detection.
- A long-held compare level that is cleared while still high, which separates edge capture from level capture.
- Pending bits latched while the interrupt function is off, which shows the line is gated rather than the capture.
- A control write with the wrong select field, which must leave the function unchanged.

// File: rtl/ctr_irq_hub.sv
module ctr_irq_hub #(
  parameter int NCH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] ev_carry,
  input  logic [7:0] ev_borrow,
  input  logic [7:0] ev_compare,
  input  logic [7:0] ev_index,
  input  logic [7:0] idx_level,
  input  logic [7:0] cable_ok,
  output logic       irq,
  output logic       cnt_reset
);
  localparam logic [4:0] A_STAT  = 5'h10;
  localparam logic [4:0] A_OP    = 5'h11;
  localparam logic [4:0] A_EN    = 5'h12;
  localparam logic [4:0] A_LEVEL = 5'h16;
  localparam logic [4:0] A_CABLE = 5'h17;
  localparam logic [1:0] SEL_FLAG = 2'b10;

  logic [7:0] pend, en, sel, sel_q, cab_mask;
  logic       ie;
  logic       op_wr;

  assign op_wr = wr_en && (addr == A_OP);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [1:0] fn;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) fn <= 2'd0;
      else if (wr_en && addr == 5'(2 * i + 1) && wdata[6:5] == SEL_FLAG) fn <= wdata[4:3];

    always_comb
      case (fn)
        2'd0:    sel[i] = ev_carry[i];
        2'd1:    sel[i] = ev_compare[i];
        2'd2:    sel[i] = ev_carry[i] | ev_borrow[i];
        default: sel[i] = ev_index[i];
      endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q     <= '0;
      pend      <= '0;
      en        <= '0;
      ie        <= 1'b0;
      cnt_reset <= 1'b0;
      cab_mask  <= '1;
    end else begin
      sel_q <= sel;
      if (op_wr) pend <= '0;
      else       pend <= pend | (sel & ~sel_q & en);
      if (op_wr) begin
        cnt_reset <= wdata[0];
        ie        <= wdata[2];
      end
      if (wr_en && addr == A_EN)    en       <= wdata;
      if (wr_en && addr == A_CABLE) cab_mask <= wdata;
    end

  assign irq = ie && (pend != '0);

  always_comb
    case (addr)
      A_STAT:  rdata = pend;
      A_OP:    rdata = {5'd0, ie, 1'b0, cnt_reset};
      A_EN:    rdata = en;
      A_LEVEL: rdata = idx_level;
      A_CABLE: rdata = cab_mask | cable_ok;
      default: rdata = 8'h00;
    endcase
endmodule

// File: rtl/ctr_irq_hub_chk.sv
module ctr_irq_hub_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] pend,
  input logic [7:0] en,
  input logic       ie,
  input logic       irq,
  input logic       cnt_reset
);
  assert_clear_on_op_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h11) |=> (pend == 8'h00));

  assert_set_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == 8'h00));

  assert_sticky_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((~pend & $past(pend)) == 8'h00) || $past(wr_en && addr == 5'h11)));

  assert_op_reset_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 5'h11) |=> (cnt_reset == $past(wdata[0])));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ie |-> !irq);
endmodule

bind ctr_irq_hub ctr_irq_hub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .pend(pend), .en(en), .ie(ie), .irq(irq), .cnt_reset(cnt_reset)
);

// File: tb/ctr_irq_hub_bench.sv
`timescale 1ns/1ps
module ctr_irq_hub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] ev_carry = '0, ev_borrow = '0, ev_compare = '0, ev_index = '0;
  logic [7:0] idx_level = '0, cable_ok = '0;
  logic       irq, cnt_reset;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ctr_irq_hub u_ctr_irq_hub (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .ev_carry(ev_carry), .ev_borrow(ev_borrow), .ev_compare(ev_compare), .ev_index(ev_index),
    .idx_level(idx_level), .cable_ok(cable_ok), .irq(irq), .cnt_reset(cnt_reset)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input int kind, input int ch);
    @(negedge clk);
    case (kind)
      0: ev_carry[ch] = 1'b1;
      1: ev_borrow[ch] = 1'b1;
      2: ev_compare[ch] = 1'b1;
      default: ev_index[ch] = 1'b1;
    endcase
    @(negedge clk);
    ev_carry = '0; ev_borrow = '0; ev_compare = '0; ev_index = '0;
    @(negedge clk);
  endtask

  function automatic bit picked(input int f, input int kind);
    case (f)
      0: return kind == 0;
      1: return kind == 2;
      2: return kind == 0 || kind == 1;
      default: return kind == 3;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(5'h10, r); check("R1 status", r, 8'h00);
    rd(5'h11, r); check("R1 op", r, 8'h00);
    rd(5'h12, r); check("R1 enable", r, 8'h00);
    rd(5'h17, r); check("R1 cable", r, 8'hFF);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 cnt_reset", {7'd0, cnt_reset}, 8'h00);

    // R3 R4 R8 sweep: every function x event kind x channel
    wr(5'h12, 8'hFF);
    for (int f = 0; f < 4; f++) begin
      for (int ch = 0; ch < 8; ch++) wr(5'(2 * ch + 1), 8'h40 | 8'(f << 3));
      for (int k = 0; k < 4; k++)
        for (int ch = 0; ch < 8; ch++) begin
          logic [7:0] exp;
          wr(5'h11, 8'h04);
          pulse(k, ch);
          exp = picked(f, k) ? 8'(1 << ch) : 8'h00;
          rd(5'h10, r); check("R3 picked event sets status", r, exp);
          check("R8 irq follows pending", {7'd0, irq}, {7'd0, exp != 8'h00});
        end
    end

    // R2 wrong select field leaves function, data write ignored
    wr(5'h01, 8'h40);
    wr(5'h01, 8'h38);
    wr(5'h00, 8'h58);
    wr(5'h11, 8'h04);
    pulse(0, 0);
    rd(5'h10, r); check("R2 function unchanged by other writes", r, 8'h01);
    wr(5'h11, 8'h04);
    pulse(3, 0);
    rd(5'h10, r); check("R2 index not picked", r, 8'h00);

    // R4 enable gating
    for (int ch = 0; ch < 8; ch++) wr(5'(2 * ch + 1), 8'h40);
    wr(5'h12, 8'hFE);
    wr(5'h11, 8'h04);
    pulse(0, 0);
    rd(5'h10, r); check("R4 disabled channel stays clear", r, 8'h00);
    pulse(0, 1);
    rd(5'h10, r); check("R4 enabled channel sets", r, 8'h02);
    pulse(0, 2);
    rd(5'h10, r); check("R4 bits accumulate", r, 8'h06);

    // R5 held level sets only once
    wr(5'h12, 8'hFF);
    wr(5'h03, 8'h48);
    wr(5'h11, 8'h04);
    @(negedge clk); ev_compare[1] = 1'b1;
    repeat (3) @(negedge clk);
    rd(5'h10, r); check("R5 held level sets", r, 8'h02);
    wr(5'h11, 8'h04);
    repeat (3) @(negedge clk);
    rd(5'h10, r); check("R5 no re-set while high", r, 8'h00);
    @(negedge clk); ev_compare[1] = 1'b0;
    @(negedge clk); ev_compare[1] = 1'b1;
    @(negedge clk); ev_compare[1] = 1'b0;
    rd(5'h10, r); check("R5 new edge sets", r, 8'h02);

    // R6 any data clears
    pulse(0, 5);
    wr(5'h11, 8'h00);
    rd(5'h10, r); check("R6 clear with zero data", r, 8'h00);

    // R8 pending with function disabled
    pulse(0, 4);
    rd(5'h10, r); check("R8 pending latched while disabled", r, 8'h10);
    check("R8 irq low when disabled", {7'd0, irq}, 8'h00);

    // R7 operation register
    wr(5'h11, 8'h05);
    check("R7 cnt_reset high", {7'd0, cnt_reset}, 8'h01);
    rd(5'h11, r); check("R7 op readback", r, 8'h05);
    wr(5'h11, 8'h04);
    check("R7 cnt_reset low", {7'd0, cnt_reset}, 8'h00);

    // R9 index levels
    for (int v = 0; v < 256; v += 37) begin
      idx_level = 8'(v);
      rd(5'h16, r); check("R9 index level", r, 8'(v));
    end

    // R10 cable status
    cable_ok = 8'hA5;
    rd(5'h17, r); check("R10 all masked", r, 8'hFF);
    wr(5'h17, 8'h0F);
    rd(5'h17, r); check("R10 partly enabled", r, 8'hAF);
    wr(5'h17, 8'h00);
    rd(5'h17, r); check("R10 all enabled", r, 8'hA5);
    cable_ok = 8'h00;
    rd(5'h17, r); check("R10 all faulted", r, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule